// File: doc/BRIEF.md
# Embedded-Clock Word Serializer Transmitter

The block turns a 10-bit parallel word into a 12-bit serial frame and shifts it out one bit per cycle of a bit clock that runs at exactly twelve times the word rate. A fixed high bit opens every frame and a fixed low bit closes it. That pair forms the embedded clock, so the line changes level at least once in every frame. The word clock arrives as an ordinary input. It is synchronized into the bit-clock domain, and a selectable edge of it captures the parallel word.

Two sync request inputs let a link partner ask for a training pattern. Once a request has been seen for enough consecutive words, the data is replaced by six ones followed by six zeros. After reset or power-up the block models transmitter lock with a counter of word periods. Nothing drives the line until that counter expires. A drive enable and a power-down input further gate the output. Turning the drive enable off and on again resumes the running stream. Power-down forces a fresh lock.

Top module: `emb_ser_tx`

## Requirements
- R1: Each frame is 12 bits sent least significant first, one bit per `clk_i` cycle: bit 0 is the start bit (1), bits 1 to 10 carry `word_i[0]` to `word_i[9]`, and bit 11 is the stop bit (0).
- R2: With `edge_rise_i` = 1 the word is captured on a rising edge of `wclk_i`. The start bit appears on `ser_o` in the third `clk_i` cycle after the edge.
- R3: With `edge_rise_i` = 0 the word is captured on a falling edge of `wclk_i`, with the same latency. Rising edges then capture nothing.
- R4: A capture at which `sync_a_i` or `sync_b_i` is high counts toward a sync request, and a capture with both low clears the count. From the 5th consecutive counted capture on, the frame is the sync pattern: bits 0 to 5 are 1 and bits 6 to 11 are 0. Shorter requests leave the data frames unchanged.
- R5: Sync frames continue while either sync input is high. The first capture at which both are low carries data again.
- R6: After reset, `ready_o` and `oe_o` stay low until `LOCK_WORDS` (default 512, inside the 510 to 2049 word window) words have been captured. The word of that capture is the first frame sent, and `ready_o` rises in the same cycle as its start bit.
- R7: `oe_o` is high only while `ready_o` is high and `drv_en_i` and `pwr_on_i` were high in the previous cycle. `ser_o` is 0 whenever `oe_o` is low.
- R8: `drv_en_i` low forces `oe_o` low from the next cycle on. The stream keeps running meanwhile. When the enable returns, frames resume at once, in order, with no new lock.
- R9: `pwr_on_i` low clears `ready_o` and `oe_o` from the next cycle on. Once it is high again, a full lock of `LOCK_WORDS` captures is needed before any frame is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, 12x the word rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wclk_i | input | 1 | Word clock, sampled in the bit domain |
| edge_rise_i | input | 1 | 1: capture on rising word-clock edge, 0: on falling edge |
| word_i | input | 10 | Parallel data word |
| sync_a_i | input | 1 | Sync request, first source |
| sync_b_i | input | 1 | Sync request, second source |
| drv_en_i | input | 1 | Line drive enable |
| pwr_on_i | input | 1 | 1: operating, 0: power-down |
| ser_o | output | 1 | Serial bit, 0 while not driving |
| oe_o | output | 1 | Output drive enable (0 means high impedance) |
| ready_o | output | 1 | Transmit lock achieved |

## Verification
The lock counter's final capture and the promotion of a sync request to the sync pattern can land on the same word strobe. In that case the very first frame after lock must already be a sync frame. The bench provokes this by holding a sync input high through the whole acquisition, twice: from reset in falling-edge mode, and after a power-down exit in rising-edge mode. The scoreboard then requires the first driven frame to be six ones and six zeros, with the output held off for the whole frame before it.

// File: rtl/emb_ser_pkg.sv
package emb_ser_pkg;

  typedef enum logic [1:0] {
    LK_OFF = 2'd0,
    LK_ACQ = 2'd1,
    LK_RUN = 2'd2
  } lk_state_e;

  localparam logic FRAME_START = 1'b1;
  localparam logic FRAME_STOP  = 1'b0;

endpackage

// File: rtl/emb_ser_edge.sv
module emb_ser_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wclk_i,
  input  logic rise_sel_i,
  output logic strobe_o
);

  logic [SYNC_STAGES:0] stg_q;

  for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= 1'b0;
        else         stg_q[g] <= wclk_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= 1'b0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  logic cur, dly;
  assign cur = stg_q[SYNC_STAGES-1];
  assign dly = stg_q[SYNC_STAGES];

  // one-cycle pulse on the selected polarity only
  assign strobe_o = rise_sel_i ? (cur & ~dly) : (~cur & dly);

endmodule

// File: rtl/emb_ser_lock.sv
module emb_ser_lock
  import emb_ser_pkg::*;
#(
  parameter int unsigned LOCK_WORDS = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_on_i,
  input  logic strobe_i,
  output logic run_o,
  output logic run_next_o
);

  localparam int unsigned CNT_W = $clog2(LOCK_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_WORDS - 1);

  lk_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!pwr_on_i) begin
      state_d = LK_OFF;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        LK_OFF: begin
          state_d = LK_ACQ;
          cnt_d   = '0;
        end
        LK_ACQ: begin
          if (strobe_i) begin
            if (cnt_q == CNT_LAST) begin
              state_d = LK_RUN;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        LK_RUN:  state_d = LK_RUN;
        default: state_d = LK_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LK_ACQ;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_o      = (state_q == LK_RUN);
  assign run_next_o = (state_d == LK_RUN);

endmodule

// File: rtl/emb_ser_frame.sv
module emb_ser_frame
  import emb_ser_pkg::*;
#(
  parameter int unsigned WORD_W     = 10,
  parameter int unsigned SYNC_WORDS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_on_i,
  input  logic              strobe_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sync_req_i,
  output logic              bit_o
);

  localparam int unsigned FRAME_W = WORD_W + 2;
  localparam int unsigned HALF_W  = FRAME_W / 2;
  localparam int unsigned SC_W    = $clog2(SYNC_WORDS + 1);
  localparam logic [SC_W-1:0] SC_MAX  = SC_W'(SYNC_WORDS);
  localparam logic [SC_W-1:0] SC_HIT  = SC_W'(SYNC_WORDS - 1);

  logic [FRAME_W-1:0] sync_pat;
  for (genvar i = 0; i < FRAME_W; i++) begin : g_pat
    assign sync_pat[i] = (i < HALF_W);
  end

  logic [SC_W-1:0]    sc_q;
  logic               sync_hit;
  logic [FRAME_W-1:0] frame, sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sc_q <= '0;
    else if (!pwr_on_i)   sc_q <= '0;
    else if (strobe_i) begin
      if (!sync_req_i)         sc_q <= '0;
      else if (sc_q != SC_MAX) sc_q <= sc_q + 1'b1;
    end
  end

  // this capture completes the required run of requests
  assign sync_hit = sync_req_i && (sc_q >= SC_HIT);
  assign frame    = sync_hit ? sync_pat : {FRAME_STOP, word_i, FRAME_START};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '0;
    else if (!pwr_on_i) sh_q <= '0;
    else if (load_i)    sh_q <= frame;
    else                sh_q <= {1'b0, sh_q[FRAME_W-1:1]};
  end

  assign bit_o = sh_q[0];

endmodule

// File: rtl/emb_ser_tx.sv
module emb_ser_tx #(
  parameter int unsigned WORD_W      = 10,
  parameter int unsigned LOCK_WORDS  = 512,
  parameter int unsigned SYNC_WORDS  = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wclk_i,
  input  logic              edge_rise_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  input  logic              drv_en_i,
  input  logic              pwr_on_i,
  output logic              ser_o,
  output logic              oe_o,
  output logic              ready_o
);

  logic strobe_w, run_w, run_next_w, load_w, bit_w, oe_q;

  emb_ser_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wclk_i     (wclk_i),
    .rise_sel_i (edge_rise_i),
    .strobe_o   (strobe_w)
  );

  emb_ser_lock #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_on_i   (pwr_on_i),
    .strobe_i   (strobe_w),
    .run_o      (run_w),
    .run_next_o (run_next_w)
  );

  // lock-completing capture already loads its frame
  assign load_w = strobe_w & run_next_w;

  emb_ser_frame #(.WORD_W(WORD_W), .SYNC_WORDS(SYNC_WORDS)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_on_i   (pwr_on_i),
    .strobe_i   (strobe_w),
    .load_i     (load_w),
    .word_i     (word_i),
    .sync_req_i (sync_a_i | sync_b_i),
    .bit_o      (bit_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= run_next_w & drv_en_i & pwr_on_i;
  end

  assign oe_o    = oe_q;
  assign ser_o   = oe_q & bit_w;
  assign ready_o = run_w;

endmodule

// File: rtl/emb_ser_tx_chk.sv
module emb_ser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic drv_en_i,
  input logic pwr_on_i,
  input logic ser_o,
  input logic oe_o,
  input logic ready_o,
  input logic strobe_i,
  input logic load_i
);

  p_start_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && drv_en_i |=> ser_o);

  p_stop_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i, 12) |-> !ser_o);

  p_lock_on_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(strobe_i));

  p_load_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ready_o);

  p_drive_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> ready_o && $past(drv_en_i) && $past(pwr_on_i));

  p_quiet_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !ser_o);

  p_en_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_en_i |=> !oe_o);

  p_pwr_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_i |=> !ready_o && !oe_o);

endmodule

bind emb_ser_tx emb_ser_tx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .drv_en_i (drv_en_i),
  .pwr_on_i (pwr_on_i),
  .ser_o    (ser_o),
  .oe_o     (oe_o),
  .ready_o  (ready_o),
  .strobe_i (strobe_w),
  .load_i   (load_w)
);

// File: tb/sim_emb_ser_tx.sv
`timescale 1ns/1ps
module sim_emb_ser_tx;

  localparam int LOCK_WORDS = 512;
  localparam int SYNC_WORDS = 5;
  localparam int K_CHK = 0, K_OFF = 1, K_SKIP = 2;

  typedef struct {
    int          kind;
    logic [11:0] bits;
    string       tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wclk = 1'b0;
  logic       rise_sel = 1'b1;
  logic [9:0] word = '0;
  logic       sync_a = 1'b0, sync_b = 1'b0;
  logic       drv_en = 1'b1, pwr_on = 1'b1;
  logic       en_next = 1'b1, pwr_next = 1'b1;
  logic       ser, oe, ready;

  int checks = 0, errors = 0;
  int up_cnt = 0, sync_run = 0;
  item_t exp_q[$];

  bit         mon_on = 1'b0;
  int         mph = 0;
  int         start_ph = 3;
  bit         seen = 1'b0, all_on = 1'b1, all_off = 1'b1;
  logic [11:0] got = '0;

  always #4 clk = ~clk;

  emb_ser_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .wclk_i(wclk), .edge_rise_i(rise_sel),
    .word_i(word), .sync_a_i(sync_a), .sync_b_i(sync_b),
    .drv_en_i(drv_en), .pwr_on_i(pwr_on),
    .ser_o(ser), .oe_o(oe), .ready_o(ready)
  );

  task automatic check(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one word period, pushes the frame it expects
  task automatic word_cycle(input logic [9:0] d, input string tag);
    item_t it;
    bit req, locked, toggled;
    req = sync_a | sync_b;
    if (pwr_on) begin
      up_cnt++;
      sync_run = req ? sync_run + 1 : 0;
    end else begin
      up_cnt = 0;
      sync_run = 0;
    end
    locked  = pwr_on && (up_cnt >= LOCK_WORDS);
    toggled = (en_next != drv_en) || (pwr_next != pwr_on);
    it.bits = (sync_run >= SYNC_WORDS) ? 12'h03F : {1'b0, d, 1'b1};
    it.kind = toggled ? K_SKIP : ((locked && drv_en) ? K_CHK : K_OFF);
    it.tag  = tag;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 0) begin
        wclk = 1'b1;
        if (rise_sel) begin word = d; exp_q.push_back(it); end
      end
      if (i == 6) begin
        wclk = 1'b0;
        if (!rise_sel) begin word = d; exp_q.push_back(it); end
        drv_en = en_next;
        pwr_on = pwr_next;
      end
    end
  endtask

  // monitor: gathers each frame window and compares with the queue head
  always @(negedge clk) begin
    if (mon_on) begin
      int b;
      item_t it;
      b = (mph + 12 - start_ph) % 12;
      if (b == 0) begin
        seen = 1'b1; all_on = 1'b1; all_off = 1'b1; got = '0;
      end
      got[b]  = ser;
      all_on  = all_on & oe;
      all_off = all_off & !oe;
      if (b == 11 && seen) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "queue", got, '0);
        end else begin
          it = exp_q.pop_front();
          if (it.kind == K_CHK)
            check(all_on && (got == it.bits), it.tag, got, it.bits);
          else if (it.kind == K_OFF)
            check(all_off && (got == '0), it.tag, got, 12'h000);
        end
      end
      mph = (mph + 1) % 12;
    end
  end

  task automatic start_session(input bit rise);
    mon_on = 1'b0;
    exp_q.delete();
    rst_n = 1'b0;
    rise_sel = rise;
    wclk = 1'b0;
    up_cnt = 0;
    sync_run = 0;
    repeat (5) @(negedge clk);
    check(!oe && !ser && !ready, "R6 reset", {9'd0, oe, ser, ready}, 12'h000);
    rst_n = 1'b1;
    #1;
    mph = 0;
    start_ph = rise ? 3 : 9;
    seen = 1'b0;
    mon_on = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // session 1: rising-edge capture
    start_session(1'b1);
    for (int n = 1; n < LOCK_WORDS; n++) word_cycle(10'(n * 37), "R6 pre-lock");
    check(ready == 1'b0, "R6 ready early", {11'd0, ready}, 12'd0);
    word_cycle(10'h2B4, "R6 first frame");
    check(ready == 1'b1, "R6 ready", {11'd0, ready}, 12'd1);
    word_cycle(10'h3FF, "R1 ones");
    word_cycle(10'h000, "R1 zeros");
    word_cycle(10'h2AA, "R1 alt");
    word_cycle(10'h155, "R2 alt");
    word_cycle(10'h001, "R1 lsb");
    word_cycle(10'h200, "R1 msb");
    for (int k = 0; k < 10; k++) word_cycle(10'(1 << k), "R2 walk");

    // short request: data unchanged
    sync_a = 1'b1;
    for (int k = 0; k < 3; k++) word_cycle(10'(k + 100), "R4 short");
    sync_a = 1'b0;
    word_cycle(10'h0F0, "R4 after short");
    // long request
    sync_a = 1'b1;
    for (int k = 0; k < 4; k++) word_cycle(10'(k + 200), "R4 pre-sync");
    for (int k = 0; k < 3; k++) word_cycle(10'(k + 300), "R4 sync");
    sync_b = 1'b1;
    word_cycle(10'h111, "R5 both");
    sync_a = 1'b0;
    word_cycle(10'h222, "R5 b only");
    word_cycle(10'h233, "R5 b only");
    sync_b = 1'b0;
    word_cycle(10'h333, "R5 released");
    word_cycle(10'h0AB, "R5 data");

    // drive enable off and back
    en_next = 1'b0;
    word_cycle(10'h101, "R8 edge");
    for (int k = 0; k < 3; k++) word_cycle(10'(k + 400), "R8 off");
    check(ready == 1'b1, "R8 lock kept", {11'd0, ready}, 12'd1);
    en_next = 1'b1;
    word_cycle(10'h102, "R8 edge");
    word_cycle(10'h1C3, "R8 resume");
    word_cycle(10'h03C, "R7 resume");

    // power-down, relock with sync held through acquisition
    pwr_next = 1'b0;
    word_cycle(10'h0C0, "R9 edge");
    for (int k = 0; k < 3; k++) word_cycle(10'(k + 500), "R9 down");
    check(ready == 1'b0, "R9 ready low", {11'd0, ready}, 12'd0);
    sync_a = 1'b1;
    pwr_next = 1'b1;
    word_cycle(10'h0C1, "R9 edge");
    for (int n = 1; n < LOCK_WORDS; n++) word_cycle(10'(n * 11), "R9 relock");
    check(ready == 1'b0, "R9 ready early", {11'd0, ready}, 12'd0);
    word_cycle(10'h155, "R4 sync at lock");
    check(ready == 1'b1, "R9 ready", {11'd0, ready}, 12'd1);
    sync_a = 1'b0;
    word_cycle(10'h2C7, "R5 data after relock");
    word_cycle(10'h18E, "R9 data");
    word_cycle(10'h000, "R9 flush");
    word_cycle(10'h000, "R9 flush");

    // session 2: falling-edge capture, sync held from reset
    start_session(1'b0);
    sync_b = 1'b1;
    for (int n = 1; n < LOCK_WORDS; n++) word_cycle(10'(n * 5), "R3 pre-lock");
    word_cycle(10'h3A5, "R3 sync at lock");
    sync_b = 1'b0;
    word_cycle(10'h25A, "R3 data");
    word_cycle(10'h0FF, "R3 data");
    word_cycle(10'h300, "R3 data");
    word_cycle(10'h000, "R3 flush");
    word_cycle(10'h000, "R3 flush");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule